// File: doc/BRIEF.md
# Reversible-Gate 4x4 Unsigned Multiplier

A purely combinational multiplier that forms the 8-bit unsigned product of two 4-bit operands. Its structure uses nothing but three kinds of reversible gate. Each gate is bijective, so it has as many outputs as inputs. Each gate output feeds at most one gate input. No signal is split by a plain wire: a value needed in several places travels through the pass-through outputs of the gates that use it. Every constant input is a zero tied inside the block. Every gate output that does not reach the product is brought out on a 28-bit garbage bus, so no output is left dangling.

The operand-AND stage is a 4x4 grid of gates. An x bit travels along its row and a y bit travels down its column. Where both values still have further users, a controlled-controlled-NOT gate keeps both of them. At the last use of at least one of the two values, a Peres gate is used instead. After the grid, a carry-save network adds up the sixteen terms. It uses eight four-line adder gates as full adders and four Peres gates as half adders. The network is ordered so that the longest chain through it passes six gates.

Top module: `revmul4x4`

## Requirements
- R1: For every one of the 256 pairs of unsigned operands, `prod` equals `a_op * b_op`.
- R2: `prod[0]` equals `a_op[0] & b_op[0]` for every operand pair.
- R3: Every bit of `garbage` is a known 0 or 1 (never X or Z) whenever both operands are known.
- R4: The Peres primitive maps (a,b,c) to (a, a^b, (a&b)^c), and its 8 input vectors give 8 distinct output vectors.
- R5: The controlled-controlled-NOT primitive maps (a,b,c) to (a, b, (a&b)^c), and its 8 input vectors give 8 distinct output vectors.
- R6: The four-line adder primitive maps (a,b,c,d) to (a, b, a^b^c, ((a^b)&c)^(a&b)^d), and its 16 input vectors give 16 distinct output vectors.
- R7: `prod` is zero exactly when at least one operand is zero.
- R8: The largest product, 15 x 15, gives `prod` = 8'hE1, and `prod` never exceeds 225.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_op | input | 4 | First unsigned operand |
| b_op | input | 4 | Second unsigned operand |
| prod | output | 8 | Unsigned product |
| garbage | output | 28 | Gate outputs that do not form part of the product |

## Verification
The assertions assume that both operands carry two-valued bits. They check nothing while either operand still holds X or Z, which is the case before the first stimulus. The bench drives only 0 and 1 values and sets both operands before it samples anything. Every product check therefore takes place on known inputs, and the garbage bus is only ever judged for known-ness under those same conditions.

// File: rtl/rev_prims.sv
`timescale 1ns/1ps
module rg_peres (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ^ b;
  assign r = (a & b) ^ c;
endmodule

module rg_toffoli (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = b;
  assign r = (a & b) ^ c;
endmodule

module rg_fadd4 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  assign p = a;
  assign q = b;
  assign r = a ^ b ^ c;
  assign s = ((a ^ b) & c) ^ (a & b) ^ d;
endmodule

// File: rtl/revmul4x4.sv
`timescale 1ns/1ps
module revmul4x4 (
  input  logic [3:0]  a_op,
  input  logic [3:0]  b_op,
  output logic [7:0]  prod,
  output logic [27:0] garbage
);
  logic [3:0]  xw [4];
  logic [3:0]  yw [4];
  logic [3:0]  pp [4];
  logic [7:0]  gpp;
  logic [3:0]  gha;
  logic [15:0] gfa;

  for (genvar i = 0; i < 4; i++) begin : g_row
    for (genvar j = 0; j < 4; j++) begin : g_col
      if (j == 0) begin : g_xin
        assign xw[i][0] = a_op[i];
      end
      if (i == 0) begin : g_yin
        assign yw[0][j] = b_op[j];
      end
      if (i < 3 && j < 3) begin : g_keep
        rg_toffoli u_g (.a(xw[i][j]), .b(yw[i][j]), .c(1'b0),
                        .p(xw[i][j+1]), .q(yw[i+1][j]), .r(pp[i][j]));
      end else if (i == 3 && j < 3) begin : g_lastrow
        rg_peres u_g (.a(xw[i][j]), .b(yw[i][j]), .c(1'b0),
                      .p(xw[i][j+1]), .q(gpp[j]), .r(pp[i][j]));
      end else if (i < 3) begin : g_lastcol
        rg_peres u_g (.a(yw[i][j]), .b(xw[i][j]), .c(1'b0),
                      .p(yw[i+1][j]), .q(gpp[3+i]), .r(pp[i][j]));
      end else begin : g_corner
        rg_peres u_g (.a(xw[i][j]), .b(yw[i][j]), .c(1'b0),
                      .p(gpp[6]), .q(gpp[7]), .r(pp[i][j]));
      end
    end
  end

  logic c1, s2a, c2a, c2b;
  logic s3a, c3a, s3b, c3b, c3c;
  logic s4a, c4a, s4b, c4b, c4c;
  logic s5a, c5a, c5b;

  assign prod[0] = pp[0][0];

  rg_peres u_ha1 (.a(pp[0][1]), .b(pp[1][0]), .c(1'b0),
                  .p(gha[0]), .q(prod[1]), .r(c1));

  rg_fadd4 u_fa2a (.a(pp[0][2]), .b(pp[1][1]), .c(pp[2][0]), .d(1'b0),
                   .p(gfa[0]), .q(gfa[1]), .r(s2a), .s(c2a));
  rg_peres u_ha2 (.a(s2a), .b(c1), .c(1'b0),
                  .p(gha[1]), .q(prod[2]), .r(c2b));

  rg_fadd4 u_fa3a (.a(pp[0][3]), .b(pp[1][2]), .c(pp[2][1]), .d(1'b0),
                   .p(gfa[2]), .q(gfa[3]), .r(s3a), .s(c3a));
  rg_fadd4 u_fa3b (.a(pp[3][0]), .b(s3a), .c(c2a), .d(1'b0),
                   .p(gfa[4]), .q(gfa[5]), .r(s3b), .s(c3b));
  rg_peres u_ha3 (.a(s3b), .b(c2b), .c(1'b0),
                  .p(gha[2]), .q(prod[3]), .r(c3c));

  rg_fadd4 u_fa4a (.a(pp[1][3]), .b(pp[2][2]), .c(pp[3][1]), .d(1'b0),
                   .p(gfa[6]), .q(gfa[7]), .r(s4a), .s(c4a));
  rg_fadd4 u_fa4b (.a(s4a), .b(c3a), .c(c3b), .d(1'b0),
                   .p(gfa[8]), .q(gfa[9]), .r(s4b), .s(c4b));
  rg_peres u_ha4 (.a(s4b), .b(c3c), .c(1'b0),
                  .p(gha[3]), .q(prod[4]), .r(c4c));

  rg_fadd4 u_fa5a (.a(pp[2][3]), .b(pp[3][2]), .c(c4a), .d(1'b0),
                   .p(gfa[10]), .q(gfa[11]), .r(s5a), .s(c5a));
  rg_fadd4 u_fa5b (.a(s5a), .b(c4b), .c(c4c), .d(1'b0),
                   .p(gfa[12]), .q(gfa[13]), .r(prod[5]), .s(c5b));

  rg_fadd4 u_fa6 (.a(pp[3][3]), .b(c5a), .c(c5b), .d(1'b0),
                  .p(gfa[14]), .q(gfa[15]), .r(prod[6]), .s(prod[7]));

  assign garbage = {gfa, gha, gpp};
endmodule

// File: rtl/revmul4x4_chk.sv
`timescale 1ns/1ps
module revmul4x4_chk (
  input logic [3:0]  a_op,
  input logic [3:0]  b_op,
  input logic [7:0]  prod,
  input logic [27:0] garbage
);
  always_comb begin
    if (!$isunknown({a_op, b_op})) begin
      p_product_r1: assert (prod == ({4'b0, a_op} * {4'b0, b_op}));
      p_lsb_r2: assert (prod[0] == (a_op[0] & b_op[0]));
      p_garbage_known_r3: assert (!$isunknown(garbage));
      p_zero_iff_r7: assert (((a_op == 4'd0) || (b_op == 4'd0)) == (prod == 8'd0));
      p_range_r8: assert (prod <= 8'd225);
    end
  end
endmodule

bind revmul4x4 revmul4x4_chk u_chk (
  .a_op(a_op), .b_op(b_op), .prod(prod), .garbage(garbage)
);

// File: tb/revmul4x4_tb.sv
`timescale 1ns/1ps
module revmul4x4_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  a_op = 4'd0, b_op = 4'd0;
  logic [7:0]  prod;
  logic [27:0] garbage;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  revmul4x4 u_dut (.a_op(a_op), .b_op(b_op), .prod(prod), .garbage(garbage));

  logic [2:0] pg_i = 3'd0, tg_i = 3'd0;
  logic [3:0] fa_i = 4'd0;
  logic [2:0] pg_o, tg_o;
  logic [3:0] fa_o;
  rg_peres   u_pg (.a(pg_i[2]), .b(pg_i[1]), .c(pg_i[0]), .p(pg_o[2]), .q(pg_o[1]), .r(pg_o[0]));
  rg_toffoli u_tg (.a(tg_i[2]), .b(tg_i[1]), .c(tg_i[0]), .p(tg_o[2]), .q(tg_o[1]), .r(tg_o[0]));
  rg_fadd4   u_fa (.a(fa_i[3]), .b(fa_i[2]), .c(fa_i[1]), .d(fa_i[0]),
                   .p(fa_o[3]), .q(fa_o[2]), .r(fa_o[1]), .s(fa_o[0]));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (a=%0d b=%0d)", req, act, exp, a_op, b_op);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b);
    @(posedge clk);
    a_op = a;
    b_op = b;
    @(negedge clk);
  endtask

  task automatic t_initial;
    apply(4'd0, 4'd0);
    chk(prod == 8'd0, "R7 zero operands", {24'd0, prod}, 32'd0);
    chk(!$isunknown(garbage), "R3 garbage known", {4'd0, garbage}, 32'd0);
  endtask

  task automatic t_all_pairs;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(4'(a), 4'(b));
        chk(prod == 8'(a * b), "R1 product", {24'd0, prod}, 32'(a * b));
        chk(!$isunknown(garbage), "R3 garbage known", {4'd0, garbage}, 32'd0);
      end
  endtask

  task automatic t_lsb;
    for (int k = 0; k < 4; k++) begin
      apply(4'((k >> 1) | 4'b0110), 4'((k & 1) | 4'b1010));
      chk(prod[0] == ((k >> 1) & k & 1), "R2 product lsb", {31'd0, prod[0]}, 32'((k >> 1) & k & 1));
    end
  endtask

  task automatic t_zero;
    for (int v = 0; v < 16; v++) begin
      apply(4'(v), 4'd0);
      chk(prod == 8'd0, "R7 b zero", {24'd0, prod}, 32'd0);
      apply(4'd0, 4'(v));
      chk(prod == 8'd0, "R7 a zero", {24'd0, prod}, 32'd0);
    end
    apply(4'd1, 4'd1);
    chk(prod != 8'd0, "R7 nonzero", {24'd0, prod}, 32'd1);
  endtask

  task automatic t_max;
    apply(4'hF, 4'hF);
    chk(prod == 8'hE1, "R8 max product", {24'd0, prod}, 32'hE1);
    apply(4'hF, 4'hE);
    chk(prod == 8'd210, "R8 near max", {24'd0, prod}, 32'd210);
  endtask

  task automatic t_peres;
    bit [7:0] seen = '0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] e;
      pg_i = 3'(v);
      #1;
      e = {pg_i[2], pg_i[2] ^ pg_i[1], (pg_i[2] & pg_i[1]) ^ pg_i[0]};
      chk(pg_o == e, "R4 peres map", {29'd0, pg_o}, {29'd0, e});
      chk(!seen[pg_o], "R4 peres distinct", {29'd0, pg_o}, 32'(v));
      seen[pg_o] = 1'b1;
    end
  endtask

  task automatic t_toffoli;
    bit [7:0] seen = '0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] e;
      tg_i = 3'(v);
      #1;
      e = {tg_i[2], tg_i[1], (tg_i[2] & tg_i[1]) ^ tg_i[0]};
      chk(tg_o == e, "R5 ccnot map", {29'd0, tg_o}, {29'd0, e});
      chk(!seen[tg_o], "R5 ccnot distinct", {29'd0, tg_o}, 32'(v));
      seen[tg_o] = 1'b1;
    end
  endtask

  task automatic t_adder;
    bit [15:0] seen = '0;
    for (int v = 0; v < 16; v++) begin
      logic [3:0] e;
      logic a, b, c, d;
      fa_i = 4'(v);
      #1;
      {a, b, c, d} = fa_i;
      e = {a, b, a ^ b ^ c, ((a ^ b) & c) ^ (a & b) ^ d};
      chk(fa_o == e, "R6 adder map", {28'd0, fa_o}, {28'd0, e});
      chk(!seen[fa_o], "R6 adder distinct", {28'd0, fa_o}, 32'(v));
      seen[fa_o] = 1'b1;
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_initial();
    t_all_pairs();
    t_lsb();
    t_zero();
    t_max();
    t_peres();
    t_toffoli();
    t_adder();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule